// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes 24 interrupt input lines to a downstream local interrupt unit. Each line owns a redirection entry that holds a vector, a delivery mode, a destination mode, a trigger mode, a mask and an 8-bit destination. Software reaches these entries indirectly over a 32-bit memory-mapped bus. It first writes an index into a select register and then reads or writes a data window. Every entry takes two consecutive indices: a configuration word and a destination word.

A rising input latches a pending request. When an entry is pending and unmasked, the block places a message on a valid/ready handshake. The message carries the vector, the delivery mode, the trigger mode, the destination and the destination mode. Edge-triggered entries drop their request once the message is taken. Level-triggered entries instead set a remote-request flag that blocks any further message until an end-of-interrupt with the same vector arrives. Several eligible entries are served one handshake at a time, lowest index first. A global enable input shuts off bus access.

Top module: `intRouter`

## Requirements
- R1: Bus offset 0x00 is the 32-bit select register, read and written as a whole. Offset 0x10 is the data window. A write to any other offset changes nothing, and a read from any other offset returns 0.
- R2: Window index 0 reads the 4-bit ID in bits 27:24, and a write there stores data bits 27:24. Index 1 reads 0x00170011, which is version 0x11 with 23 in bits 23:16. Index 2 reads the ID and ignores writes. Indices 3 to 0x0F and indices of 0x40 and above read 0.
- R3: Entry n is at index 0x10+2n (configuration) and index 0x11+2n (destination). Only bits 31:24 of the destination word are kept, and the other bits read 0. Configuration bits are: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, trigger 15 (1 = level), mask 16.
- R4: After reset every configuration word reads 0x00010000, every destination word reads 0, and no message is offered.
- R5: Configuration bits 12 (delivery status), 14 (remote request) and 31:17 are read-only. A write leaves them unchanged.
- R6: An edge entry latches a request only on a low-to-high input change. If the entry is masked at that moment, the event is lost. One rise yields exactly one message, and the request clears when the handshake completes.
- R7: A level entry latches a rise even while it is masked, and delivers the request once it is unmasked. Delivery sets bit 14, and no further message for that entry is sent while bit 14 is set.
- R8: When the input of a level entry goes low, the entry's pending request is withdrawn.
- R9: An end-of-interrupt with vector V clears bit 14 of every entry whose vector is V. If the entry's input is still high, the entry then delivers again.
- R10: Only delivery modes 0 and 1 produce a message. A request in any other mode is consumed without a message.
- R11: A message carries the vector, the mode, the trigger bit, destination bits 31:24 and the destination-mode bit. Its fields stay stable while valid is high and ready is low.
- R12: When several entries are eligible, the lowest index is served first, and one entry is served per handshake.
- R13: While enable is low, all bus reads return 0 and all bus writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global bus access enable |
| busWrEn | input | 1 | Bus write strobe |
| busAddr | input | 8 | Bus byte offset |
| busWrData | input | 32 | Bus write data |
| busRdData | output | 32 | Bus read data (combinational from busAddr) |
| irqIn | input | 24 | Interrupt input lines |
| eoiValid | input | 1 | End-of-interrupt broadcast strobe |
| eoiVector | input | 8 | Vector of the end-of-interrupt |
| msgValid | output | 1 | Delivery message valid |
| msgReady | input | 1 | Downstream accepts message |
| msgVector | output | 8 | Message vector |
| msgDelivMode | output | 3 | Message delivery mode |
| msgLevel | output | 1 | Message trigger mode (1 = level) |
| msgDest | output | 8 | Message destination |
| msgDestLogical | output | 1 | Message destination mode |

## Verification
The bench targets the remote-request cycle of a level entry. A design that forgets to block redelivery would send a second message before the end-of-interrupt. A design that fails to withdraw the request on a falling input would deliver after the input is already low. A masked edge rise is checked to vanish, because a design that latches it anyway fires when the entry is unmasked. Masked level rises are checked to survive. Writes of all-ones and all-zeros confirm the read-only bits. Simultaneous requests expose a wrong priority order, and a non-fixed delivery mode exposes a design that still emits a message.

// File: rtl/intRouterPkg.sv
package intRouterPkg;
  parameter int IRQ_COUNT = 24;
  localparam int IDX_W = $clog2(IRQ_COUNT);

  localparam logic [7:0]  SEL_OFF     = 8'h00;
  localparam logic [7:0]  WIN_OFF     = 8'h10;
  localparam logic [31:0] FIRST_ENTRY = 32'h10;
  localparam logic [7:0]  VERSION     = 8'h11;

  typedef struct packed {
    logic [7:0] vector;
    logic [2:0] mode;
    logic       destLogical;
    logic       polarity;
    logic       level;
    logic       mask;
  } entryCfg_t;

  typedef struct packed {
    logic             cfgWr;
    logic             dstWr;
    logic [IDX_W-1:0] wrIdx;
    logic [31:0]      wrData;
    logic             consume;
    logic [IDX_W-1:0] consumeIdx;
    logic             inFlight;
    logic [IDX_W-1:0] flightIdx;
  } ctlStrobes_t;
endpackage

// File: rtl/intRouterDp.sv
module intRouterDp
  import intRouterPkg::*;
#(
  parameter int N  = IRQ_COUNT,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  irqIn,
  input  logic          eoiValid,
  input  logic [7:0]    eoiVector,
  input  ctlStrobes_t   strb,
  input  logic [IW-1:0] rdIdx,
  input  logic [IW-1:0] pickIdx,
  output logic [31:0]   cfgWord,
  output logic [31:0]   dstWord,
  output logic [N-1:0]  eligVec,
  output entryCfg_t     pickCfg,
  output logic [7:0]    pickDest
);
  entryCfg_t  cfgQ [N];
  logic [7:0] dstQ [N];
  logic [N-1:0] irrQ, remQ, lastQ;
  logic [N-1:0] rise, fall;

  assign rise = irqIn & ~lastQ;
  assign fall = ~irqIn & lastQ;

  always_ff @(posedge clk) begin
    if (!rstN) lastQ <= '0;
    else       lastQ <= irqIn;
  end

  for (genvar i = 0; i < N; i++) begin : gEntry
    logic hitCfg, hitDst, consumeHere, irrN, remN;
    assign hitCfg      = strb.cfgWr && (strb.wrIdx == IW'(i));
    assign hitDst      = strb.dstWr && (strb.wrIdx == IW'(i));
    assign consumeHere = strb.consume && (strb.consumeIdx == IW'(i));

    always_comb begin
      irrN = irrQ[i];
      if (consumeHere && !cfgQ[i].level) irrN = 1'b0;
      if (fall[i] && cfgQ[i].level)      irrN = 1'b0;
      if (rise[i] && (cfgQ[i].level || !cfgQ[i].mask)) irrN = 1'b1;
      remN = remQ[i];
      if (eoiValid && (eoiVector == cfgQ[i].vector)) remN = 1'b0;
      if (consumeHere && cfgQ[i].level)              remN = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgQ[i] <= '{vector: 8'h0, mode: 3'h0, destLogical: 1'b0,
                     polarity: 1'b0, level: 1'b0, mask: 1'b1};
        dstQ[i] <= '0;
        irrQ[i] <= 1'b0;
        remQ[i] <= 1'b0;
      end else begin
        if (hitCfg) begin
          cfgQ[i].vector      <= strb.wrData[7:0];
          cfgQ[i].mode        <= strb.wrData[10:8];
          cfgQ[i].destLogical <= strb.wrData[11];
          cfgQ[i].polarity    <= strb.wrData[13];
          cfgQ[i].level       <= strb.wrData[15];
          cfgQ[i].mask        <= strb.wrData[16];
        end
        if (hitDst) dstQ[i] <= strb.wrData[31:24];
        irrQ[i] <= irrN;
        remQ[i] <= remN;
      end
    end

    assign eligVec[i] = irrQ[i] && !cfgQ[i].mask && (!cfgQ[i].level || !remQ[i]);
  end

  logic delivStatus;
  assign delivStatus = strb.inFlight && (strb.flightIdx == rdIdx);
  assign cfgWord = {15'b0, cfgQ[rdIdx].mask, cfgQ[rdIdx].level, remQ[rdIdx],
                    cfgQ[rdIdx].polarity, delivStatus, cfgQ[rdIdx].destLogical,
                    cfgQ[rdIdx].mode, cfgQ[rdIdx].vector};
  assign dstWord  = {dstQ[rdIdx], 24'b0};
  assign pickCfg  = cfgQ[pickIdx];
  assign pickDest = dstQ[pickIdx];

  logic unusedWrBits;
  assign unusedWrBits = ^{strb.wrData[23:17], strb.wrData[14], strb.wrData[12]};

  // Checks
  logic [IW-1:0] consIdx;
  assign consIdx = strb.consumeIdx;

  assert_edge_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.consume && !cfgQ[consIdx].level && !rise[consIdx]) |=> !irrQ[$past(consIdx)]);

  assert_level_blocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.consume && cfgQ[consIdx].level) |-> !remQ[consIdx]);

  assert_level_sets_remote_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.consume && cfgQ[consIdx].level && !(hitAny(consIdx))) |=> remQ[$past(consIdx)]);

  function automatic logic hitAny(input logic [IW-1:0] idx);
    return strb.cfgWr && (strb.wrIdx == idx);
  endfunction
endmodule

// File: rtl/intRouterCtl.sv
module intRouterCtl
  import intRouterPkg::*;
#(
  parameter int N  = IRQ_COUNT,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          busWrEn,
  input  logic [7:0]    busAddr,
  input  logic [31:0]   busWrData,
  output logic [31:0]   busRdData,
  input  logic [N-1:0]  eligVec,
  input  logic [31:0]   cfgWord,
  input  logic [31:0]   dstWord,
  input  entryCfg_t     pickCfg,
  input  logic [7:0]    pickDest,
  output ctlStrobes_t   strb,
  output logic [IW-1:0] rdIdx,
  output logic [IW-1:0] pickIdx,
  output logic          msgValid,
  input  logic          msgReady,
  output logic [7:0]    msgVector,
  output logic [2:0]    msgDelivMode,
  output logic          msgLevel,
  output logic [7:0]    msgDest,
  output logic          msgDestLogical
);
  localparam logic [31:0] LAST_ENTRY = FIRST_ENTRY + 32'(2 * N);
  localparam logic [31:0] VERSION_WORD = {8'h0, 8'(N - 1), 8'h0, VERSION};

  logic [31:0] selQ;
  logic [3:0]  idQ;
  logic selHit, winHit, wrEn, inTable;
  logic [31:0] entryOff;

  assign selHit   = busAddr == SEL_OFF;
  assign winHit   = busAddr == WIN_OFF;
  assign wrEn     = enable && busWrEn;
  assign inTable  = (selQ >= FIRST_ENTRY) && (selQ < LAST_ENTRY);
  assign entryOff = selQ - FIRST_ENTRY;
  assign rdIdx    = inTable ? entryOff[IW:1] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
      idQ  <= '0;
    end else begin
      if (wrEn && selHit) selQ <= busWrData;
      if (wrEn && winHit && selQ == 32'd0) idQ <= busWrData[27:24];
    end
  end

  always_comb begin
    busRdData = '0;
    if (enable) begin
      if (selHit) busRdData = selQ;
      else if (winHit) begin
        if (selQ == 32'd0 || selQ == 32'd2) busRdData = {4'b0, idQ, 24'b0};
        else if (selQ == 32'd1)             busRdData = VERSION_WORD;
        else if (inTable)                   busRdData = selQ[0] ? dstWord : cfgWord;
      end
    end
  end

  // Arbitration: lowest eligible index
  logic anyElig, modeOk, busyQ;
  logic [IW-1:0] grantQ;
  always_comb begin
    anyElig = 1'b0;
    pickIdx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (eligVec[k]) begin
        anyElig = 1'b1;
        pickIdx = IW'(k);
      end
    end
  end
  assign modeOk = pickCfg.mode[2:1] == 2'b00;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ          <= 1'b0;
      grantQ         <= '0;
      msgVector      <= '0;
      msgDelivMode   <= '0;
      msgLevel       <= 1'b0;
      msgDest        <= '0;
      msgDestLogical <= 1'b0;
    end else if (!busyQ && anyElig && modeOk) begin
      busyQ          <= 1'b1;
      grantQ         <= pickIdx;
      msgVector      <= pickCfg.vector;
      msgDelivMode   <= pickCfg.mode;
      msgLevel       <= pickCfg.level;
      msgDest        <= pickDest;
      msgDestLogical <= pickCfg.destLogical;
    end else if (busyQ && msgReady) begin
      busyQ <= 1'b0;
    end
  end
  assign msgValid = busyQ;

  always_comb begin
    strb.cfgWr      = wrEn && winHit && inTable && !selQ[0];
    strb.dstWr      = wrEn && winHit && inTable && selQ[0];
    strb.wrIdx      = rdIdx;
    strb.wrData     = busWrData;
    strb.consume    = (busyQ && msgReady) || (!busyQ && anyElig && !modeOk);
    strb.consumeIdx = busyQ ? grantQ : pickIdx;
    strb.inFlight   = busyQ;
    strb.flightIdx  = grantQ;
  end

  logic unusedCfg;
  assign unusedCfg = ^{pickCfg.polarity, pickCfg.mask};

  // Checks
  assert_msg_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgVector) && $stable(msgDest)
                                 && $stable(msgDelivMode) && $stable(msgLevel)));

  assert_msg_mode_R10: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgDelivMode[2:1] == 2'b00));

  assert_bus_gated_R13: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ($stable(selQ) && $stable(idQ)));

  assert_one_pick_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && anyElig && modeOk) |=> (msgValid && (grantQ == $past(pickIdx))));
endmodule

// File: rtl/intRouter.sv
module intRouter
  import intRouterPkg::*;
#(
  parameter int N  = IRQ_COUNT,
  parameter int IW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         busWrEn,
  input  logic [7:0]   busAddr,
  input  logic [31:0]  busWrData,
  output logic [31:0]  busRdData,
  input  logic [N-1:0] irqIn,
  input  logic         eoiValid,
  input  logic [7:0]   eoiVector,
  output logic         msgValid,
  input  logic         msgReady,
  output logic [7:0]   msgVector,
  output logic [2:0]   msgDelivMode,
  output logic         msgLevel,
  output logic [7:0]   msgDest,
  output logic         msgDestLogical
);
  ctlStrobes_t   strb;
  logic [IW-1:0] rdIdx, pickIdx;
  logic [31:0]   cfgWord, dstWord;
  logic [N-1:0]  eligVec;
  entryCfg_t     pickCfg;
  logic [7:0]    pickDest;

  intRouterCtl #(.N(N), .IW(IW)) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .eligVec(eligVec), .cfgWord(cfgWord), .dstWord(dstWord),
    .pickCfg(pickCfg), .pickDest(pickDest), .strb(strb),
    .rdIdx(rdIdx), .pickIdx(pickIdx), .msgValid(msgValid),
    .msgReady(msgReady), .msgVector(msgVector), .msgDelivMode(msgDelivMode),
    .msgLevel(msgLevel), .msgDest(msgDest), .msgDestLogical(msgDestLogical)
  );

  intRouterDp #(.N(N), .IW(IW)) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .eoiValid(eoiValid),
    .eoiVector(eoiVector), .strb(strb), .rdIdx(rdIdx), .pickIdx(pickIdx),
    .cfgWord(cfgWord), .dstWord(dstWord), .eligVec(eligVec),
    .pickCfg(pickCfg), .pickDest(pickDest)
  );
endmodule

// File: tb/intRouter_bench.sv
module intRouter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b1;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h0;
  logic [31:0] busWrData = 32'h0;
  logic [31:0] busRdData;
  logic [23:0] irqIn = '0;
  logic        eoiValid = 1'b0;
  logic [7:0]  eoiVector = 8'h0;
  logic        msgValid;
  logic        msgReady = 1'b0;
  logic [7:0]  msgVector;
  logic [2:0]  msgDelivMode;
  logic        msgLevel;
  logic [7:0]  msgDest;
  logic        msgDestLogical;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  intRouter u_intRouter (
    .clk(clk), .rstN(rstN), .enable(enable), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqIn(irqIn), .eoiValid(eoiValid), .eoiVector(eoiVector),
    .msgValid(msgValid), .msgReady(msgReady), .msgVector(msgVector),
    .msgDelivMode(msgDelivMode), .msgLevel(msgLevel), .msgDest(msgDest),
    .msgDestLogical(msgDestLogical)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic regWr(input logic [31:0] sel, input logic [31:0] d);
    busWr(8'h00, sel);
    busWr(8'h10, d);
  endtask

  task automatic regRd(input logic [31:0] sel, output logic [31:0] d);
    busWr(8'h00, sel);
    busRd(8'h10, d);
  endtask

  task automatic pulse(input int i);
    @(negedge clk); irqIn[i] = 1'b1;
    @(negedge clk);
    @(negedge clk); irqIn[i] = 1'b0;
  endtask

  task automatic sendEoi(input logic [7:0] v);
    @(negedge clk); eoiValid = 1'b1; eoiVector = v;
    @(negedge clk); eoiValid = 1'b0;
  endtask

  task automatic ack;
    @(negedge clk); msgReady = 1'b1;
    @(negedge clk); msgReady = 1'b0;
  endtask

  task automatic waitMsg(input string req, input logic [7:0] vec);
    int n = 0;
    while (!msgValid && n < 20) begin
      @(negedge clk); n++;
    end
    check({req, " msg valid"}, 32'(msgValid), 32'd1);
    check({req, " msg vector"}, 32'(msgVector), 32'(vec));
  endtask

  task automatic noMsg(input string req, input int cycles);
    logic seen = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (msgValid) seen = 1'b1;
    end
    check({req, " no msg"}, 32'(seen), 32'd0);
  endtask

  task automatic tReset;
    logic [31:0] d;
    check("R4 idle", 32'(msgValid), 32'd0);
    regRd(32'h10, d);        check("R4 cfg0", d, 32'h0001_0000);
    regRd(32'h3E, d);        check("R4 cfg23", d, 32'h0001_0000);
    regRd(32'h3F, d);        check("R4 dst23", d, 32'h0);
  endtask

  task automatic tBus;
    logic [31:0] d;
    busWr(8'h00, 32'hDEAD_BEEF);
    busRd(8'h00, d);         check("R1 select rw", d, 32'hDEAD_BEEF);
    busRd(8'h08, d);         check("R1 other offset reads 0", d, 32'h0);
    busWr(8'h08, 32'h1234_5678);
    busRd(8'h00, d);         check("R1 other offset write ignored", d, 32'hDEAD_BEEF);
  endtask

  task automatic tIdVer;
    logic [31:0] d;
    regRd(32'h1, d);         check("R2 version", d, 32'h0017_0011);
    regWr(32'h0, 32'hFFFF_FFFF);
    regRd(32'h0, d);         check("R2 id write", d, 32'h0F00_0000);
    regWr(32'h2, 32'h0);
    regRd(32'h2, d);         check("R2 arb id ignores write", d, 32'h0F00_0000);
    regRd(32'h5, d);         check("R2 unmapped low", d, 32'h0);
    regRd(32'h40, d);        check("R2 unmapped high", d, 32'h0);
  endtask

  task automatic tLayout;
    logic [31:0] d;
    regWr(32'h1A, 32'hFFFF_FFFF);
    regRd(32'h1A, d);        check("R3 R5 cfg writable bits", d, 32'h0001_AFFF);
    regWr(32'h1B, 32'hABCD_EF12);
    regRd(32'h1B, d);        check("R3 dst top byte", d, 32'hAB00_0000);
    regWr(32'h1A, 32'h0001_0000);
    regRd(32'h1A, d);        check("R3 cfg restore", d, 32'h0001_0000);
  endtask

  task automatic tEdge;
    logic [31:0] d;
    logic held = 1'b1;
    regWr(32'h17, 32'h0500_0000);
    regWr(32'h16, 32'h0000_0031);
    pulse(3);
    waitMsg("R6 edge", 8'h31);
    check("R11 mode", 32'(msgDelivMode), 32'd0);
    check("R11 level", 32'(msgLevel), 32'd0);
    check("R11 dest", 32'(msgDest), 32'h05);
    check("R11 destmode", 32'(msgDestLogical), 32'd0);
    regRd(32'h16, d);        check("R5 delivery status while offered", d, 32'h0000_1031);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!msgValid || msgVector != 8'h31) held = 1'b0;
    end
    check("R11 held while not ready", 32'(held), 32'd1);
    ack();
    noMsg("R6 single message", 10);
    regWr(32'h16, 32'h0001_0031);
    pulse(3);
    regWr(32'h16, 32'h0000_0031);
    noMsg("R6 masked edge dropped", 10);
  endtask

  task automatic tLevel;
    logic [31:0] d;
    regWr(32'h1F, 32'h0700_0000);
    regWr(32'h1E, 32'h0001_8047);
    @(negedge clk); irqIn[7] = 1'b1;
    noMsg("R7 masked level waits", 8);
    regWr(32'h1E, 32'h0000_8047);
    waitMsg("R7 level after unmask", 8'h47);
    check("R7 msg level bit", 32'(msgLevel), 32'd1);
    check("R11 level dest", 32'(msgDest), 32'h07);
    ack();
    regRd(32'h1E, d);        check("R7 remote set", d, 32'h0000_C047);
    regWr(32'h1E, 32'h0000_8047);
    regRd(32'h1E, d);        check("R5 remote kept on write", d, 32'h0000_C047);
    noMsg("R7 no redelivery", 10);
    sendEoi(8'h47);
    waitMsg("R9 redeliver after eoi", 8'h47);
    ack();
    @(negedge clk); irqIn[7] = 1'b0;
    sendEoi(8'h47);
    noMsg("R8 low input no delivery", 10);
    regRd(32'h1E, d);        check("R9 remote cleared", d, 32'h0000_8047);
    regWr(32'h20, 32'h0001_8048);
    @(negedge clk); irqIn[8] = 1'b1;
    @(negedge clk); @(negedge clk); irqIn[8] = 1'b0;
    regWr(32'h20, 32'h0000_8048);
    noMsg("R8 withdrawn while masked", 10);
  endtask

  task automatic tMode;
    regWr(32'h23, 32'h0900_0000);
    regWr(32'h22, 32'h0000_0249);
    pulse(9);
    noMsg("R10 mode 2 silent", 10);
    regWr(32'h22, 32'h0000_0949);
    pulse(9);
    waitMsg("R10 mode 1", 8'h49);
    check("R10 mode field", 32'(msgDelivMode), 32'd1);
    check("R11 logical dest", 32'(msgDestLogical), 32'd1);
    ack();
  endtask

  task automatic tPrio;
    regWr(32'h18, 32'h0000_0054);
    regWr(32'h28, 32'h0000_0062);
    @(negedge clk); irqIn[4] = 1'b1; irqIn[12] = 1'b1;
    waitMsg("R12 lowest first", 8'h54);
    ack();
    waitMsg("R12 second", 8'h62);
    ack();
    noMsg("R12 only two", 8);
    @(negedge clk); irqIn[4] = 1'b0; irqIn[12] = 1'b0;
  endtask

  task automatic tEnable;
    logic [31:0] d;
    busWr(8'h00, 32'h0000_0001);
    @(negedge clk); enable = 1'b0;
    busRd(8'h10, d);         check("R13 read zero", d, 32'h0);
    busWr(8'h00, 32'h0000_0010);
    @(negedge clk); enable = 1'b1;
    busRd(8'h00, d);         check("R13 write ignored", d, 32'h0000_0001);
  endtask

  task automatic finish;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBus();
    tIdVer();
    tLayout();
    tEdge();
    tLevel();
    tMode();
    tPrio();
    tEnable();
    finish();
  end
endmodule